// File: doc/BRIEF.md
# Banked Cartridge Mapper with Clock Registers

This block sits between an 8-bit CPU bus and a cartridge's storage. The bus has a 16-bit address, a byte of write data, and one-cycle read and write strobes. For the two ROM areas of the CPU map, the block computes a linear ROM address. The low area passes straight through. The upper area is offset by a 7-bit bank register. ROM contents live outside the block, which only drives the address.

A single 8 KiB window at 0xA000–0xBFFF is shared. It serves one of four banks of external RAM, held in an internal array, or one of five clock registers: seconds, minutes, hours, day-low and day-high. Which one the window serves is chosen by a write to the select range.

The clock counters themselves belong to a neighbouring block. The mapper sends it masked register writes through a one-hot write-enable. It also issues a latch strobe when a write of 0x00 to the latch range is followed by a write of 0x01. On that strobe the mapper keeps a snapshot of the live counter values. Clock reads in the window return that frozen copy, so software sees a coherent time.

Top module: `cart_bank_mapper`

## Requirements
- R1: For `cpu_addr` in 0x0000–0x3FFF, `rom_hit` is 1 and `rom_addr` equals `cpu_addr`, combinationally in the same cycle.
- R2: For `cpu_addr` in 0x4000–0x7FFF, `rom_addr` = bank × 0x4000 + `cpu_addr[13:0]`. The ROM bank register resets to 1.
- R3: A write to 0x2000–0x3FFF loads the ROM bank from `cpu_wdata[6:0]`, with bit 7 ignored and a value of 0 stored as 1. The new bank applies from the next cycle.
- R4: A write to 0x0000–0x1FFF enables the window when `cpu_wdata[3:0]` is 0xA and disables it for any other value. The window is disabled after reset.
- R5: A write to 0x4000–0x5FFF works as follows. Values 0x00–0x03 set the RAM bank to that value and route the window to RAM. Values 0x08, 0x09, 0x0A, 0x0B and 0x0C route the window to clock register index 0 to 4 (seconds, minutes, hours, day-low, day-high). Any other value leaves both the routing and the RAM bank unchanged.
- R6: With the window enabled and routed to RAM, a window access reaches byte bank × 2^RAM_OFS_W + `cpu_addr[RAM_OFS_W-1:0]`. Higher window address bits alias. The default RAM_OFS_W is 8; 13 gives full 8 KiB banks. Read data appears on `cpu_rdata` in the cycle after the read strobe.
- R7: While the window is disabled, or before any routing has been chosen, window reads return 0xFF and window writes change neither the RAM nor `rtc_we`.
- R8: A window write routed to clock register i raises `rtc_we[i]` alone for one cycle, in the cycle after the write. In that cycle `rtc_wdata` carries the byte masked by register: 0x3F for index 0 and 1, 0x1F for 2, 0xFF for 3 and 0xC1 for 4.
- R9: Clock register reads return the snapshot byte i. Byte i is `rtc_live[8i+7:8i]` as captured at the last latch, unmasked. Before any latch they return 0xFF.
- R10: Each write to 0x6000–0x7FFF records its byte. A write of 0x01 whose previous write to this range was 0x00 pulses `rtc_latch` for one cycle, in the next cycle, and captures `rtc_live` at that edge. No other sequence latches, including a first write of 0x01 and 0x01 after 0x01.
- R11: For `cpu_addr` at 0x8000 and above, `rom_hit` is 0 and `rom_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one access per cycle high |
| cpu_rd | input | 1 | Read strobe, one access per cycle high |
| cpu_rdata | output | 8 | Window read data, valid the cycle after `cpu_rd` |
| rom_hit | output | 1 | Address lies in the ROM areas |
| rom_addr | output | 21 | Linear ROM byte address |
| rtc_live | input | 40 | Live clock values, byte i = register i |
| rtc_we | output | 5 | One-hot write enable to the clock block |
| rtc_wdata | output | 8 | Masked clock write data |
| rtc_latch | output | 1 | One-cycle latch strobe to the clock block |

## Verification
ROM addresses are combinational, so the bench checks them 1 ns after it applies an address. Control writes take effect at the next rising edge. Window read data, the clock write enables and data, and the latch strobe are all registered, so each is due one cycle after its strobe. The bench drives every access on a falling edge and drops the strobe on the next falling edge. It samples registered results at that same falling edge, which is the first point after the edge that produced them.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int CLK_REGS = 5;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0,
        MAP_RAM  = 2'd1,
        MAP_CLK  = 2'd2
    } win_map_e;

    typedef enum logic [1:0] {
        RD_FF  = 2'd0,
        RD_RAM = 2'd1,
        RD_CLK = 2'd2
    } rd_src_e;

    // Writable bits of each clock register
    function automatic logic [7:0] clk_mask(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: clk_mask = 8'h3F;
            3'd2:       clk_mask = 8'h1F;
            3'd3:       clk_mask = 8'hFF;
            3'd4:       clk_mask = 8'hC1;
            default:    clk_mask = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cart_map_ctrl.sv
module cart_map_ctrl
    import cart_map_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            addr_hi,
    input  logic [7:0]            wdata,
    output logic                  dev_en,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output win_map_e              win_map,
    output logic [2:0]            clk_idx,
    output logic                  latch_fire,
    output logic [CLK_REGS-1:0]   clk_we,
    output logic [7:0]            clk_wdata
);

    localparam logic [7:0] RAM_SEL_MAX = 8'((1 << RAM_BANK_W) - 1);

    typedef struct packed {
        logic                  dev_en;
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        win_map_e              win_map;
        logic [2:0]            clk_idx;
        logic [7:0]            prev_byte;
        logic                  prev_vld;
        logic [CLK_REGS-1:0]   clk_we;
        logic [7:0]            clk_wdata;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.clk_we = '0;
        latch_fire  = 1'b0;
        if (wr_en) begin
            case (addr_hi)
                3'b000: st_d.dev_en = (wdata[3:0] == 4'hA);
                3'b001: st_d.rom_bank = (wdata[ROM_BANK_W-1:0] == '0)
                                        ? ROM_BANK_W'(1) : wdata[ROM_BANK_W-1:0];
                3'b010: begin
                    if (wdata <= RAM_SEL_MAX) begin
                        st_d.ram_bank = wdata[RAM_BANK_W-1:0];
                        st_d.win_map  = MAP_RAM;
                    end else if (wdata >= 8'h08 && wdata <= 8'h0C) begin
                        st_d.win_map = MAP_CLK;
                        st_d.clk_idx = wdata[2:0];
                    end
                end
                3'b011: begin
                    latch_fire     = st_q.prev_vld && (st_q.prev_byte == 8'h00)
                                     && (wdata == 8'h01);
                    st_d.prev_byte = wdata;
                    st_d.prev_vld  = 1'b1;
                end
                3'b101: begin
                    if (st_q.dev_en && st_q.win_map == MAP_CLK) begin
                        st_d.clk_we    = CLK_REGS'(1) << st_q.clk_idx;
                        st_d.clk_wdata = wdata & clk_mask(st_q.clk_idx);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.rom_bank <= ROM_BANK_W'(1);
            st_q.win_map  <= MAP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_en    = st_q.dev_en;
    assign rom_bank  = st_q.rom_bank;
    assign ram_bank  = st_q.ram_bank;
    assign win_map   = st_q.win_map;
    assign clk_idx   = st_q.clk_idx;
    assign clk_we    = st_q.clk_we;
    assign clk_wdata = st_q.clk_wdata;

    // R3
    rom_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_hi == 3'b001 && wdata[ROM_BANK_W-1:0] == '0) |=> rom_bank == ROM_BANK_W'(1));
    // R4
    dev_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_hi == 3'b000 && wdata[3:0] != 4'hA) |=> !dev_en);
    // R8
    clk_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_we));
    // R8
    hour_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_we[2] |-> clk_wdata[7:5] == 3'b000);

endmodule

// File: rtl/cart_map_ram.sv
module cart_map_ram #(
    parameter int BANK_W = 2,
    parameter int OFS_W  = 8
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic                      re,
    input  logic [BANK_W+OFS_W-1:0]   addr,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata
);

    localparam int DEPTH = 1 << (BANK_W + OFS_W);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
        if (re) rdata_q <= mem_q[addr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/cart_map_snap.sv
module cart_map_snap
    import cart_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch,
    input  logic [8*CLK_REGS-1:0] live,
    output logic [8*CLK_REGS-1:0] snap,
    output logic                  snap_vld
);

    typedef struct packed {
        logic [8*CLK_REGS-1:0] val;
        logic                  vld;
    } snap_s;

    snap_s sn_d, sn_q;

    always_comb begin
        sn_d = sn_q;
        if (latch) begin
            sn_d.val = live;
            sn_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sn_q <= '0;
        else        sn_q <= sn_d;
    end

    assign snap     = sn_q.val;
    assign snap_vld = sn_q.vld;

    // R10
    snap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> snap_vld);

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2,
    parameter int RAM_OFS_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [15:0]               cpu_addr,
    input  logic [7:0]                cpu_wdata,
    input  logic                      cpu_wr,
    input  logic                      cpu_rd,
    output logic [7:0]                cpu_rdata,
    output logic                      rom_hit,
    output logic [ROM_BANK_W+13:0]    rom_addr,
    input  logic [8*CLK_REGS-1:0]     rtc_live,
    output logic [CLK_REGS-1:0]       rtc_we,
    output logic [7:0]                rtc_wdata,
    output logic                      rtc_latch
);

    localparam int ROM_ADDR_W = ROM_BANK_W + 14;

    logic                  dev_en;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    win_map_e              win_map;
    logic [2:0]            clk_idx;
    logic                  latch_fire;
    logic [8*CLK_REGS-1:0] snap;
    logic                  snap_vld;
    logic [7:0]            ram_rdata;
    logic                  in_win;
    logic                  ram_sel;

    cart_map_ctrl #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr_hi(cpu_addr[15:13]),
        .wdata(cpu_wdata), .dev_en(dev_en), .rom_bank(rom_bank), .ram_bank(ram_bank),
        .win_map(win_map), .clk_idx(clk_idx), .latch_fire(latch_fire),
        .clk_we(rtc_we), .clk_wdata(rtc_wdata)
    );

    cart_map_snap snap_i (
        .clk(clk), .rst_n(rst_n), .latch(latch_fire), .live(rtc_live),
        .snap(snap), .snap_vld(snap_vld)
    );

    assign in_win  = (cpu_addr[15:13] == 3'b101);
    assign ram_sel = in_win && dev_en && (win_map == MAP_RAM);

    cart_map_ram #(.BANK_W(RAM_BANK_W), .OFS_W(RAM_OFS_W)) ram_i (
        .clk(clk), .we(cpu_wr && ram_sel), .re(cpu_rd && ram_sel),
        .addr({ram_bank, cpu_addr[RAM_OFS_W-1:0]}), .wdata(cpu_wdata),
        .rdata(ram_rdata)
    );

    // ROM address: combinational
    always_comb begin
        rom_hit = !cpu_addr[15];
        if (!rom_hit)
            rom_addr = '0;
        else if (cpu_addr[14])
            rom_addr = {rom_bank, cpu_addr[13:0]};
        else
            rom_addr = ROM_ADDR_W'(cpu_addr[13:0]);
    end

    // Read path and latch strobe
    typedef struct packed {
        rd_src_e    rd_src;
        logic [7:0] clk_byte;
        logic       latch;
    } top_s;

    top_s tp_d, tp_q;

    always_comb begin
        tp_d       = tp_q;
        tp_d.latch = latch_fire;
        if (cpu_rd) begin
            tp_d.rd_src = RD_FF;
            if (in_win && dev_en) begin
                case (win_map)
                    MAP_RAM: tp_d.rd_src = RD_RAM;
                    MAP_CLK: begin
                        if (snap_vld) begin
                            tp_d.rd_src   = RD_CLK;
                            tp_d.clk_byte = snap[{clk_idx, 3'b000} +: 8];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q        <= '0;
            tp_q.rd_src <= RD_FF;
        end else begin
            tp_q <= tp_d;
        end
    end

    always_comb begin
        case (tp_q.rd_src)
            RD_RAM:  cpu_rdata = ram_rdata;
            RD_CLK:  cpu_rdata = tp_q.clk_byte;
            default: cpu_rdata = 8'hFF;
        endcase
    end

    assign rtc_latch = tp_q.latch;

    // R2
    upper_bank_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_hit && cpu_addr[14]) |-> rom_addr[ROM_ADDR_W-1:14] != '0);
    // R7
    rd_disabled_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && in_win && !dev_en) |=> cpu_rdata == 8'hFF);
    // R9
    rd_nolatch_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && in_win && dev_en && win_map == MAP_CLK && !snap_vld) |=> cpu_rdata == 8'hFF);
    // R10
    latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_latch |-> $past(cpu_wr && cpu_addr[15:13] == 3'b011 && cpu_wdata == 8'h01));

endmodule

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        rom_hit;
    logic [20:0] rom_addr;
    logic [39:0] rtc_live = '0;
    logic [4:0]  rtc_we;
    logic [7:0]  rtc_wdata;
    logic        rtc_latch;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cart_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_hit(rom_hit),
        .rom_addr(rom_addr), .rtc_live(rtc_live), .rtc_we(rtc_we),
        .rtc_wdata(rtc_wdata), .rtc_latch(rtc_latch)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    function automatic logic [7:0] pat(input int b, input int o);
        return 8'((b * 59) ^ (o * 7) ^ 8'hA5);
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            0, 1: return 8'h3F;
            2:    return 8'h1F;
            3:    return 8'hFF;
            default: return 8'hC1;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        cpu_addr = 16'h4000; #1;
        chk("R2 reset bank 1", rom_addr, 32'h4000);
        chk("R8 reset rtc_we", rtc_we, 0);
        chk("R10 reset rtc_latch", rtc_latch, 0);
        @(negedge clk);
        rd(16'hA000, v); chk("R4 R7 disabled after reset", v, 8'hFF);

        // R1 low ROM sweep
        for (int a = 0; a < 16'h4000; a += 16'h00FF) begin
            cpu_addr = 16'(a); #1;
            chk("R1 low rom", {10'd0, rom_hit, rom_addr}, {10'd0, 1'b1, 21'(a)});
        end
        @(negedge clk);

        // R11 above ROM
        for (int a = 16'h8000; a <= 16'hFFFF; a += 16'h0F0F) begin
            cpu_addr = 16'(a); #1;
            chk("R11 non-rom", {rom_hit, rom_addr}, 22'd0);
        end
        @(negedge clk);

        // R2 R3 full bank sweep, bit 7 set on odd banks
        for (int b = 0; b < 128; b++) begin
            wr(16'h2000 + 16'(b * 64), 8'(b) | ((b % 2 == 1) ? 8'h80 : 8'h00));
            for (int k = 0; k < 3; k++) begin
                int off;
                off = (k == 0) ? 0 : (k == 1) ? 16'h1234 : 16'h3FFF;
                cpu_addr = 16'h4000 + 16'(off); #1;
                chk("R2 R3 banked rom", rom_addr, 32'(((b == 0) ? 1 : b) * 16'h4000 + off));
            end
            @(negedge clk);
        end

        // R7 enabled but not yet routed
        wr(16'h0000, 8'h0A);
        rd(16'hA010, v); chk("R7 unrouted read", v, 8'hFF);
        wr(16'hA010, 8'h55); chk("R7 unrouted write no rtc_we", rtc_we, 0);

        // R9 clock read before any latch
        wr(16'h4000, 8'h08);
        rd(16'hA000, v); chk("R9 read before latch", v, 8'hFF);

        // R5 R6 fill all RAM banks, with alias addresses
        for (int b = 0; b < 4; b++) begin
            wr(16'h5FFF, 8'(b));
            for (int o = 0; o < 256; o++)
                wr(16'hA000 + 16'(o) + ((o % 3 == 0) ? 16'h1C00 : 16'h0000), pat(b, o));
        end
        for (int b = 0; b < 4; b++) begin
            wr(16'h4000, 8'(b));
            for (int o = 0; o < 256; o++) begin
                rd(16'hA000 + 16'(o) + ((o % 5 == 0) ? 16'h0700 : 16'h0000), v);
                chk("R6 ram readback", v, pat(b, o));
            end
        end

        // R5 ignored select values keep bank 2 and RAM routing
        wr(16'h4000, 8'h02);
        wr(16'h4000, 8'h05);
        wr(16'h4000, 8'h0D);
        wr(16'h4000, 8'h80);
        rd(16'hA033, v); chk("R5 ignored select", v, pat(2, 16'h33));

        // R4 R7 disable by non-A nibble, write ignored
        wr(16'h1FFF, 8'h0B);
        rd(16'hA033, v); chk("R4 disabled read", v, 8'hFF);
        wr(16'hA033, 8'h00);
        wr(16'h0100, 8'hFA);
        rd(16'hA033, v); chk("R4 R7 write ignored while disabled", v, pat(2, 16'h33));

        // R8 clock register writes
        for (int i = 0; i < 5; i++) begin
            wr(16'h4000, 8'h08 + 8'(i));
            wr(16'hA000 + 16'(i), 8'hFF);
            chk("R8 rtc_we one-hot", rtc_we, 32'(1 << i));
            chk("R8 rtc_wdata mask", rtc_wdata, mask_of(i));
            @(negedge clk);
            chk("R8 rtc_we single cycle", rtc_we, 0);
            wr(16'hA000, 8'hA5);
            chk("R8 rtc_wdata A5", rtc_wdata, 8'hA5 & mask_of(i));
        end
        // R7 disabled clock write
        wr(16'h0000, 8'h00);
        wr(16'hA000, 8'h12);
        chk("R7 disabled clock write", rtc_we, 0);
        wr(16'h0000, 8'h0A);

        // R10 latch sequence
        rtc_live = 40'hE5_D4_17_3B_2A;
        wr(16'h6000, 8'h01);
        chk("R10 first 01 no latch", rtc_latch, 0);
        wr(16'h6000, 8'h00);
        chk("R10 00 no latch", rtc_latch, 0);
        wr(16'h7FFF, 8'h01);
        chk("R10 latch pulse", rtc_latch, 1);
        @(negedge clk);
        chk("R10 latch one cycle", rtc_latch, 0);
        rtc_live = 40'h11_22_33_44_55;
        for (int i = 0; i < 5; i++) begin
            wr(16'h4000, 8'h08 + 8'(i));
            rd(16'hB000, v);
            chk("R9 R10 snapshot read", v, 8'(40'hE5_D4_17_3B_2A >> (8 * i)));
        end
        wr(16'h6000, 8'h01);
        chk("R10 01 after 01 no latch", rtc_latch, 0);
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h02);
        wr(16'h6000, 8'h01);
        chk("R10 02 breaks sequence", rtc_latch, 0);
        wr(16'h4000, 8'h0A);
        rd(16'hA000, v); chk("R9 snapshot unchanged", v, 8'h17);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule